// File: doc/BRIEF.md
# Control Register Access Router

This block sits beside the system-register decode stage of a processor core. It judges one system-register read or write aimed at the top-level control register of the lower privileged regime. That register can be reached through two encodings: a direct name, and an alias meant for use from the hypervisor level. From the instruction's encoding fields, the access direction, the current privilege level and the virtualisation controls, the router picks one outcome. The outcome is one of:

- no match, so that another decoder may claim the encoding;
- undefined;
- a trap to the hypervisor level, with syndrome class 0x18;
- a redirect to a fixed offset in the nested-virtualisation memory page;
- an access to the lower-regime register;
- an access to the hypervisor-regime register.

The decision is a priority chain. Virtual-memory trap bits are tested first and fine-grained trap bits second. The nested-virtualisation redirect comes next. Host-mode retargeting applies at the hypervisor level. The whole verdict is computed combinationally and registered once. The register storage and the memory page are not part of this block.

Top module: `sreg_route_top`

## Requirements
- R1: Only two encodings match: the direct one (op0=3, op1=0, CRn=1, CRm=0, op2=0) and the alias (the same fields except op1=5). Any other encoding gives route 0 (no match). The route codes are 0 no-match, 1 undefined, 2 trap, 3 memory redirect, 4 lower-regime register and 5 hypervisor-regime register.
- R2: A matching access at level 0 gives route 1, whatever the other inputs are.
- R3: A direct access at level 1 with the hypervisor enabled gives route 2 when the access is a read with the virtual-memory read-trap bit set, or a write with the write-trap bit set. This check wins over every other check.
- R4: For a direct access at level 1 that R3 does not trap, route 2 is given when all of the following hold: the hypervisor is enabled, the fine-grained feature is present, the monitor level is absent or its fine-grained enable is set, and the fine-grained bit matching the direction is set.
- R5: For a direct access at level 1 that neither R3 nor R4 traps, nested state 3'b111 gives route 3. Any other nested state gives route 4.
- R6: A direct access at level 2 gives route 5 in host mode and route 4 otherwise. A direct access at level 3 always gives route 4.
- R7: An alias access at level 1 gives route 3 when the nested state is 3'b101. Otherwise it gives route 2 when bit 0 of the nested state is set, and route 1 when that bit is clear.
- R8: An alias access at level 2 or 3 gives route 4 in host mode and route 1 otherwise.
- R9: The outputs are registered. They show the verdict for the inputs present at the previous rising clock edge. While reset is held they read route 0, class 0 and offset 0.
- R10: The trap class output is 0x18 exactly when the route is 2, and 0 otherwise. The offset output is 0x110 exactly when the route is 3, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| is_write | input | 1 | 1 for a write, 0 for a read |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| hyp_on | input | 1 | Hypervisor level enabled |
| mon_present | input | 1 | Monitor level implemented |
| host_mode | input | 1 | Hypervisor runs as host |
| vm_trap_rd | input | 1 | Virtual-memory trap on read |
| vm_trap_wr | input | 1 | Virtual-memory trap on write |
| fgt_feat | input | 1 | Fine-grained trap feature present |
| fgt_mon_en | input | 1 | Monitor's enable for fine-grained traps |
| fgt_rd | input | 1 | Fine-grained read trap bit |
| fgt_wr | input | 1 | Fine-grained write trap bit |
| nv_state | input | 3 | Nested-virtualisation state |
| route_q | output | 3 | Registered route code |
| trap_class_q | output | 6 | Registered syndrome class |
| mem_ofs_q | output | 12 | Registered redirect offset |

## Verification
At a direct level-1 access, three decisions compete in the same cycle: the virtual-memory trap, the fine-grained trap and the nested redirect. At the hypervisor level, host-mode retargeting and the alias checks can apply at once. Directed tasks set two or more of these conditions together, for example the read-trap bit, a fine-grained bit and nested state 3'b111 all at once, and expect the higher-priority outcome alone. A sweep then drives every combination of level, direction, trap bit and nested state through both encodings. Each registered verdict is compared one cycle later against a model written from the priority rules.

// File: rtl/sreg_route_pkg.sv
package sreg_route_pkg;

    localparam int CLS_W = 6;
    localparam int OFS_W = 12;

    localparam logic [1:0] ENC_OP0       = 2'd3;
    localparam logic [2:0] ENC_OP1_DIR   = 3'd0;
    localparam logic [2:0] ENC_OP1_ALIAS = 3'd5;
    localparam logic [3:0] ENC_CRN       = 4'd1;
    localparam logic [3:0] ENC_CRM       = 4'd0;
    localparam logic [2:0] ENC_OP2       = 3'd0;

    localparam logic [CLS_W-1:0] TRAP_CLASS = 6'h18;
    localparam logic [OFS_W-1:0] REDIR_OFS  = 12'h110;
    localparam logic [2:0]       NV_DIR_REDIR   = 3'b111;
    localparam logic [2:0]       NV_ALIAS_REDIR = 3'b101;

    typedef enum logic [2:0] {
        RT_NOMATCH  = 3'd0,
        RT_UNDEF    = 3'd1,
        RT_TRAP     = 3'd2,
        RT_MEMREDIR = 3'd3,
        RT_REG_LOW  = 3'd4,
        RT_REG_HYP  = 3'd5
    } route_e;

    typedef struct packed {
        route_e                 route;
        logic [CLS_W-1:0]       cls;
        logic [OFS_W-1:0]       ofs;
    } verdict_t;

endpackage

// File: rtl/sreg_enc_match.sv
module sreg_enc_match
    import sreg_route_pkg::*;
(
    input  logic [1:0] enc_op0,
    input  logic [2:0] enc_op1,
    input  logic [3:0] enc_crn,
    input  logic [3:0] enc_crm,
    input  logic [2:0] enc_op2,
    output logic       hit_dir,
    output logic       hit_alias
);
    logic common_ok;

    always_comb begin
        common_ok = (enc_op0 == ENC_OP0) && (enc_crn == ENC_CRN) &&
                    (enc_crm == ENC_CRM) && (enc_op2 == ENC_OP2);
        hit_dir   = common_ok && (enc_op1 == ENC_OP1_DIR);
        hit_alias = common_ok && (enc_op1 == ENC_OP1_ALIAS);
    end
endmodule

// File: rtl/sreg_trap_gate.sv
module sreg_trap_gate (
    input  logic is_write,
    input  logic hyp_on,
    input  logic mon_present,
    input  logic vm_trap_rd,
    input  logic vm_trap_wr,
    input  logic fgt_feat,
    input  logic fgt_mon_en,
    input  logic fgt_rd,
    input  logic fgt_wr,
    output logic vm_hit,
    output logic fgt_hit
);
    logic vm_bit;
    logic fgt_bit;
    logic fgt_allowed;

    always_comb begin
        vm_bit      = is_write ? vm_trap_wr : vm_trap_rd;
        fgt_bit     = is_write ? fgt_wr : fgt_rd;
        fgt_allowed = fgt_feat && (!mon_present || fgt_mon_en);
        vm_hit      = hyp_on && vm_bit;
        fgt_hit     = hyp_on && fgt_allowed && fgt_bit;
    end
endmodule

// File: rtl/sreg_route_chain.sv
module sreg_route_chain
    import sreg_route_pkg::*;
(
    input  logic       hit_dir,
    input  logic       hit_alias,
    input  logic [1:0] cur_lvl,
    input  logic       host_mode,
    input  logic       vm_hit,
    input  logic       fgt_hit,
    input  logic [2:0] nv_state,
    output route_e     route
);
    always_comb begin
        route = RT_NOMATCH;
        if (hit_dir || hit_alias) begin
            if (cur_lvl == 2'd0) begin
                route = RT_UNDEF;
            end else if (hit_dir) begin
                case (cur_lvl)
                    2'd1: begin
                        if (vm_hit)                       route = RT_TRAP;
                        else if (fgt_hit)                 route = RT_TRAP;
                        else if (nv_state == NV_DIR_REDIR) route = RT_MEMREDIR;
                        else                              route = RT_REG_LOW;
                    end
                    2'd2:    route = host_mode ? RT_REG_HYP : RT_REG_LOW;
                    default: route = RT_REG_LOW;
                endcase
            end else begin
                if (cur_lvl == 2'd1) begin
                    if (nv_state == NV_ALIAS_REDIR) route = RT_MEMREDIR;
                    else if (nv_state[0])           route = RT_TRAP;
                    else                            route = RT_UNDEF;
                end else begin
                    route = host_mode ? RT_REG_LOW : RT_UNDEF;
                end
            end
        end
    end
endmodule

// File: rtl/sreg_route_top.sv
module sreg_route_top
    import sreg_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       enc_op0,
    input  logic [2:0]       enc_op1,
    input  logic [3:0]       enc_crn,
    input  logic [3:0]       enc_crm,
    input  logic [2:0]       enc_op2,
    input  logic             is_write,
    input  logic [1:0]       cur_lvl,
    input  logic             hyp_on,
    input  logic             mon_present,
    input  logic             host_mode,
    input  logic             vm_trap_rd,
    input  logic             vm_trap_wr,
    input  logic             fgt_feat,
    input  logic             fgt_mon_en,
    input  logic             fgt_rd,
    input  logic             fgt_wr,
    input  logic [2:0]       nv_state,
    output logic [2:0]       route_q,
    output logic [CLS_W-1:0] trap_class_q,
    output logic [OFS_W-1:0] mem_ofs_q
);
    logic     hit_dir;
    logic     hit_alias;
    logic     vm_hit;
    logic     fgt_hit;
    route_e   route_c;
    verdict_t v_d;
    verdict_t v_q;

    sreg_enc_match u_match (
        .enc_op0   (enc_op0),
        .enc_op1   (enc_op1),
        .enc_crn   (enc_crn),
        .enc_crm   (enc_crm),
        .enc_op2   (enc_op2),
        .hit_dir   (hit_dir),
        .hit_alias (hit_alias)
    );

    sreg_trap_gate u_gate (
        .is_write    (is_write),
        .hyp_on      (hyp_on),
        .mon_present (mon_present),
        .vm_trap_rd  (vm_trap_rd),
        .vm_trap_wr  (vm_trap_wr),
        .fgt_feat    (fgt_feat),
        .fgt_mon_en  (fgt_mon_en),
        .fgt_rd      (fgt_rd),
        .fgt_wr      (fgt_wr),
        .vm_hit      (vm_hit),
        .fgt_hit     (fgt_hit)
    );

    sreg_route_chain u_chain (
        .hit_dir   (hit_dir),
        .hit_alias (hit_alias),
        .cur_lvl   (cur_lvl),
        .host_mode (host_mode),
        .vm_hit    (vm_hit),
        .fgt_hit   (fgt_hit),
        .nv_state  (nv_state),
        .route     (route_c)
    );

    always_comb begin
        v_d.route = route_c;
        v_d.cls   = (route_c == RT_TRAP)     ? TRAP_CLASS : '0;
        v_d.ofs   = (route_c == RT_MEMREDIR) ? REDIR_OFS  : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '{route: RT_NOMATCH, cls: '0, ofs: '0};
        end else begin
            v_q <= v_d;
        end
    end

    assign route_q      = v_q.route;
    assign trap_class_q = v_q.cls;
    assign mem_ofs_q    = v_q.ofs;

    AST_NO_MATCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_dir && !hit_alias) |=> (route_q == RT_NOMATCH)); // R1
    AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_dir || hit_alias) && cur_lvl == 2'd0) |=> (route_q == RT_UNDEF)); // R2
    AST_VM_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dir && cur_lvl == 2'd1 && hyp_on && (is_write ? vm_trap_wr : vm_trap_rd))
        |=> (route_q == RT_TRAP)); // R3
    AST_HYP_REG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q == RT_REG_HYP) |-> ($past(cur_lvl) == 2'd2 && $past(host_mode))); // R6
    AST_ALIAS_HIGH_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_alias && cur_lvl >= 2'd2 && !host_mode) |=> (route_q == RT_UNDEF)); // R8
    AST_CLASS_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q != RT_TRAP) |-> (trap_class_q == '0)); // R10
    AST_OFS_ON_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q == RT_MEMREDIR) |-> (mem_ofs_q == REDIR_OFS)); // R10
endmodule

// File: tb/sreg_route_top_test.sv
module sreg_route_top_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  enc_op0 = 2'd3;
    logic [2:0]  enc_op1 = 3'd0;
    logic [3:0]  enc_crn = 4'd1;
    logic [3:0]  enc_crm = 4'd0;
    logic [2:0]  enc_op2 = 3'd0;
    logic        is_write = 1'b0;
    logic [1:0]  cur_lvl = 2'd0;
    logic        hyp_on = 1'b0, mon_present = 1'b0, host_mode = 1'b0;
    logic        vm_trap_rd = 1'b0, vm_trap_wr = 1'b0;
    logic        fgt_feat = 1'b0, fgt_mon_en = 1'b0, fgt_rd = 1'b0, fgt_wr = 1'b0;
    logic [2:0]  nv_state = 3'd0;
    logic [2:0]  route_q;
    logic [5:0]  trap_class_q;
    logic [11:0] mem_ofs_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_route_top uut (
        .clk(clk), .rst_n(rst_n),
        .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn),
        .enc_crm(enc_crm), .enc_op2(enc_op2), .is_write(is_write),
        .cur_lvl(cur_lvl), .hyp_on(hyp_on), .mon_present(mon_present),
        .host_mode(host_mode), .vm_trap_rd(vm_trap_rd), .vm_trap_wr(vm_trap_wr),
        .fgt_feat(fgt_feat), .fgt_mon_en(fgt_mon_en), .fgt_rd(fgt_rd),
        .fgt_wr(fgt_wr), .nv_state(nv_state),
        .route_q(route_q), .trap_class_q(trap_class_q), .mem_ofs_q(mem_ofs_q)
    );

    // Reference model written from the requirement text
    function automatic void ref_model(output logic [2:0] r, output string tag);
        logic dir, ali;
        dir = enc_op0 == 2'd3 && enc_op1 == 3'd0 && enc_crn == 4'd1 && enc_crm == 4'd0 && enc_op2 == 3'd0;
        ali = enc_op0 == 2'd3 && enc_op1 == 3'd5 && enc_crn == 4'd1 && enc_crm == 4'd0 && enc_op2 == 3'd0;
        if (!dir && !ali) begin r = 3'd0; tag = "R1"; end
        else if (cur_lvl == 2'd0) begin r = 3'd1; tag = "R2"; end
        else if (dir && cur_lvl == 2'd1) begin
            if (hyp_on && (is_write ? vm_trap_wr : vm_trap_rd)) begin r = 3'd2; tag = "R3"; end
            else if (hyp_on && fgt_feat && (!mon_present || fgt_mon_en) && (is_write ? fgt_wr : fgt_rd))
                begin r = 3'd2; tag = "R4"; end
            else begin r = (nv_state == 3'b111) ? 3'd3 : 3'd4; tag = "R5"; end
        end
        else if (dir) begin
            r = (cur_lvl == 2'd2 && host_mode) ? 3'd5 : 3'd4; tag = "R6";
        end
        else if (cur_lvl == 2'd1) begin
            r = (nv_state == 3'b101) ? 3'd3 : (nv_state[0] ? 3'd2 : 3'd1); tag = "R7";
        end
        else begin r = host_mode ? 3'd4 : 3'd1; tag = "R8"; end
    endfunction

    task automatic compare(input logic [2:0] exp_r, input string tag);
        logic [5:0]  exp_c;
        logic [11:0] exp_o;
        exp_c = (exp_r == 3'd2) ? 6'h18 : 6'h0;
        exp_o = (exp_r == 3'd3) ? 12'h110 : 12'h0;
        n_vec++;
        if (route_q !== exp_r || trap_class_q !== exp_c || mem_ofs_q !== exp_o) begin
            n_bad++;
            $display("FAIL %s/R10: route=%0d class=%0h ofs=%0h expected route=%0d class=%0h ofs=%0h",
                     tag, route_q, trap_class_q, mem_ofs_q, exp_r, exp_c, exp_o);
        end
    endtask

    // Inputs are set at a falling edge; the verdict is visible at the next falling edge
    task automatic apply_ref();
        logic [2:0] r;
        string tag;
        ref_model(r, tag);
        @(posedge clk);
        @(negedge clk);
        compare(r, tag);
    endtask

    task automatic apply_exp(input logic [2:0] exp_r, input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(exp_r, tag);
    endtask

    task automatic set_enc(input logic [2:0] op1);
        enc_op0 = 2'd3; enc_op1 = op1; enc_crn = 4'd1; enc_crm = 4'd0; enc_op2 = 3'd0;
    endtask

    task automatic clear_ctl();
        is_write = 0; hyp_on = 0; mon_present = 0; host_mode = 0;
        vm_trap_rd = 0; vm_trap_wr = 0; fgt_feat = 0; fgt_mon_en = 0;
        fgt_rd = 0; fgt_wr = 0; nv_state = 3'd0;
    endtask

    task automatic t_reset();
        set_enc(3'd0); cur_lvl = 2'd1; clear_ctl();
        repeat (3) @(negedge clk);
        compare(3'd0, "R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_latency();
        set_enc(3'd0); cur_lvl = 2'd1; clear_ctl(); nv_state = 3'b111;
        apply_exp(3'd3, "R9 r5_redirect");
        hyp_on = 1; vm_trap_rd = 1;
        #1;
        compare(3'd3, "R9 hold before edge");
        apply_exp(3'd2, "R9 R3 after edge");
    endtask

    task automatic t_nomatch();
        clear_ctl(); cur_lvl = 2'd1;
        set_enc(3'd0); enc_op0 = 2'd2; apply_exp(3'd0, "R1 op0");
        set_enc(3'd1);                 apply_exp(3'd0, "R1 op1");
        set_enc(3'd0); enc_crn = 4'd2; apply_exp(3'd0, "R1 crn");
        set_enc(3'd5); enc_crm = 4'd1; apply_exp(3'd0, "R1 crm alias");
        set_enc(3'd0); enc_op2 = 3'd1; apply_exp(3'd0, "R1 op2");
    endtask

    task automatic t_lvl0();
        clear_ctl(); cur_lvl = 2'd0; host_mode = 1; hyp_on = 1; vm_trap_rd = 1; nv_state = 3'b111;
        set_enc(3'd0); apply_exp(3'd1, "R2 direct");
        set_enc(3'd5); nv_state = 3'b101; apply_exp(3'd1, "R2 alias");
    endtask

    task automatic t_priority();
        set_enc(3'd0); cur_lvl = 2'd1; clear_ctl();
        hyp_on = 1; vm_trap_rd = 1; fgt_feat = 1; fgt_rd = 1; nv_state = 3'b111;
        apply_exp(3'd2, "R3 over R4 and R5");
        vm_trap_rd = 0; vm_trap_wr = 1;
        apply_exp(3'd2, "R4 read with only write vm bit");
        mon_present = 1; fgt_mon_en = 0;
        apply_exp(3'd3, "R4 monitor gate closed -> R5");
        fgt_mon_en = 1; is_write = 1; fgt_rd = 0;
        apply_exp(3'd2, "R3 write trap");
        hyp_on = 0;
        apply_exp(3'd3, "R5 hypervisor off");
        nv_state = 3'b110;
        apply_exp(3'd4, "R5 plain register");
    endtask

    task automatic t_levels();
        clear_ctl(); set_enc(3'd0);
        cur_lvl = 2'd2; host_mode = 1; apply_exp(3'd5, "R6 host");
        host_mode = 0;                 apply_exp(3'd4, "R6 no host");
        cur_lvl = 2'd3; host_mode = 1; apply_exp(3'd4, "R6 level 3");
        set_enc(3'd5); cur_lvl = 2'd1;
        nv_state = 3'b101; apply_exp(3'd3, "R7 redirect");
        nv_state = 3'b111; apply_exp(3'd2, "R7 trap");
        nv_state = 3'b110; apply_exp(3'd1, "R7 undefined");
        cur_lvl = 2'd2; host_mode = 1; apply_exp(3'd4, "R8 host");
        cur_lvl = 2'd3; host_mode = 0; apply_exp(3'd1, "R8 no host");
    endtask

    task automatic t_sweep();
        for (int e = 0; e < 2; e++) begin
            set_enc(e == 0 ? 3'd0 : 3'd5);
            for (int v = 0; v < 32768; v++) begin
                logic [14:0] b;
                b = v[14:0];
                cur_lvl     = b[1:0];   is_write   = b[2];  hyp_on = b[3];
                mon_present = b[4];     host_mode  = b[5];
                vm_trap_rd  = b[6];     vm_trap_wr = b[7];
                fgt_feat    = b[8];     fgt_mon_en = b[9];
                fgt_rd      = b[10];    fgt_wr     = b[11];
                nv_state    = b[14:12];
                apply_ref();
            end
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_nomatch();
        t_lvl0();
        t_priority();
        t_levels();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion within %0d cycles", WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule